// File: doc/BRIEF.md
# Reset Cause Flags with Configuration Mismatch Monitor

This block keeps a small reset-cause status byte and watches a set of configuration words for corruption. Every configuration word has a shadow copy that is stored inverted. While the configuration is marked valid, the block compares each word with the complement of its shadow on every cycle. The first cycle that shows a disagreement produces a one-cycle reset request and clears the mismatch flag.

The reset sequencer sends single-cycle cause pulses for power-on and brown-out resets. The flags react in an asymmetric way. Hardware events can only clear a flag to 0. Software can only set a flag back to 1, by writing 1 to its bit through a simple write port.

Software can tell that a brown-out happened when it sees a cleared brown-out flag alongside a re-armed power-on flag. The block provides that combination as a ready-made output. The output is qualified by the brown-out detection enable.

Top module: `rst_cause_monitor`

## Requirements
- R1: While `rst_n` is low and right after it is released, `status_o` reads 8'h20: mismatch flag (bit 5) = 1, power-on flag (bit 1) = 0, brown-out flag (bit 0) = 0. Bits 7:6 and 4:2 always read 0.
- R2: A cycle with `por_evt` high clears both bit 1 and bit 0 at the next clock edge. No input other than a software write can raise bit 1.
- R3: A cycle with `bor_evt` high clears bit 0 at the next edge if `bor_en` is 1. If `bor_en` is 0, `bor_evt` leaves bit 0 unchanged.
- R4: With `sw_we` high, each 1 in `sw_wdata` bits 0, 1 or 5 sets the matching flag at the next edge. A 0 in those bits leaves the flag unchanged, and the other bits of `sw_wdata` are ignored.
- R5: When a hardware clear and a software set hit the same flag in the same cycle, the flag ends at 0.
- R6: Word i is the slice [i*WORD_W +: WORD_W] of both word buses. When `cfg_valid` is 1 and any word differs from the bitwise complement of its shadow, and the monitor is armed, `cm_reset_req` goes high for the next cycle only and bit 5 clears at that same edge.
- R7: After a request, no further request is made until a cycle occurs with no qualified mismatch. A mismatch that persists therefore gives exactly one pulse.
- R8: While `cfg_valid` is 0, no request is made, bit 5 is not cleared, and the monitor re-arms.
- R9: `bor_seen` is combinationally 1 exactly when `bor_en` is 1, bit 1 is 1 and bit 0 is 0.
- R10: Power-on and brown-out events do not change bit 5, and mismatch events do not change bits 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low initialisation of the flag logic |
| por_evt | input | 1 | Power-on reset cause pulse from the sequencer |
| bor_evt | input | 1 | Brown-out reset cause pulse from the sequencer |
| bor_en | input | 1 | Brown-out detection enabled |
| cfg_valid | input | 1 | Configuration words are loaded and may be checked |
| cfg_words | input | NUM_WORDS*WORD_W | Configuration word bus |
| shadow_words | input | NUM_WORDS*WORD_W | Complemented shadow word bus |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 8 | Software write data, 1 bits set flags |
| status_o | output | 8 | Status byte: bit 5 mismatch, bit 1 power-on, bit 0 brown-out |
| cm_reset_req | output | 1 | One-cycle configuration mismatch reset request |
| bor_seen | output | 1 | Brown-out inferred from the flags |

## Verification
The assertions assume that every input is synchronous to `clk` and free of X after reset. They also assume that a cause pulse reaches the flags at the edge that follows it. The bench drives all inputs on the falling edge and holds them for a full cycle. Shadows are drawn as exact complements, with an occasional flipped bit, so both the agreeing and the disagreeing paths are exercised. Directed phases hold a mismatch for several cycles and drop `cfg_valid` while a mismatch is present, to reach the re-arm and gating corners.

// File: rtl/rst_cause_monitor.sv
module rst_cause_monitor #(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        por_evt,
  input  logic                        bor_evt,
  input  logic                        bor_en,
  input  logic                        cfg_valid,
  input  logic [NUM_WORDS*WORD_W-1:0] cfg_words,
  input  logic [NUM_WORDS*WORD_W-1:0] shadow_words,
  input  logic                        sw_we,
  input  logic [7:0]                  sw_wdata,
  output logic [7:0]                  status_o,
  output logic                        cm_reset_req,
  output logic                        bor_seen
);

  localparam int BOR_BIT = 0;
  localparam int POR_BIT = 1;
  localparam int CM_BIT  = 5;

  logic [NUM_WORDS-1:0] word_bad;
  logic mismatch, cm_hit, armed;
  logic por_q, bor_q, cm_q;
  logic [7:0] sw_set;
  logic bor_clr;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_cmp
    assign word_bad[g] = cfg_words[g*WORD_W +: WORD_W] != ~shadow_words[g*WORD_W +: WORD_W];
  end

  assign mismatch = cfg_valid & (|word_bad);
  assign cm_hit   = mismatch & armed;
  assign sw_set   = sw_we ? sw_wdata : 8'h00;
  assign bor_clr  = por_evt | (bor_evt & bor_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_q        <= 1'b0;
      bor_q        <= 1'b0;
      cm_q         <= 1'b1;
      armed        <= 1'b1;
      cm_reset_req <= 1'b0;
    end else begin
      por_q        <= por_evt ? 1'b0 : (por_q | sw_set[POR_BIT]);
      bor_q        <= bor_clr ? 1'b0 : (bor_q | sw_set[BOR_BIT]);
      cm_q         <= cm_hit  ? 1'b0 : (cm_q  | sw_set[CM_BIT]);
      armed        <= ~mismatch;
      cm_reset_req <= cm_hit;
    end
  end

  always_comb begin
    status_o          = 8'h00;
    status_o[BOR_BIT] = bor_q;
    status_o[POR_BIT] = por_q;
    status_o[CM_BIT]  = cm_q;
  end

  assign bor_seen = bor_en & por_q & ~bor_q;

  a_r2_por_clears: assert property (@(posedge clk) disable iff (!rst_n)
    por_evt |=> (status_o[POR_BIT] == 1'b0 && status_o[BOR_BIT] == 1'b0));

  a_r2_por_no_hw_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_o[POR_BIT] && !(sw_we && sw_wdata[POR_BIT])) |=> !status_o[POR_BIT]);

  a_r3_bor_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bor_evt && bor_en) |=> !status_o[BOR_BIT]);

  a_r3_bor_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (bor_evt && !bor_en && !por_evt && status_o[BOR_BIT]) |=> status_o[BOR_BIT]);

  a_r4_sw_sets_por: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && sw_wdata[POR_BIT] && !por_evt) |=> status_o[POR_BIT]);

  a_r6_req_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cm_reset_req |-> !status_o[CM_BIT]);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cm_reset_req |=> !cm_reset_req);

  a_r8_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |=> !cm_reset_req);

  a_r10_cm_only_by_req: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[CM_BIT] |=> (status_o[CM_BIT] || cm_reset_req));

endmodule

// File: tb/rst_cause_monitor_tb_top.sv
module rst_cause_monitor_tb_top;
  localparam int NW = 4;
  localparam int WW = 16;
  localparam int BW = NW * WW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_evt = 0, bor_evt = 0, bor_en = 0, cfg_valid = 0, sw_we = 0;
  logic [BW-1:0] cfg_words, shadow_words;
  logic [7:0] sw_wdata = 8'h00;
  logic [7:0] status_o;
  logic cm_reset_req, bor_seen;

  int checks = 0;
  int fails = 0;

  logic m_por, m_bor, m_cm, m_armed, m_req;
  localparam logic [BW-1:0] BASE = 64'h0123_4567_89AB_CDEF;

  always #10 clk = ~clk;

  rst_cause_monitor #(.NUM_WORDS(NW), .WORD_W(WW)) dut_i (
    .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .bor_evt(bor_evt), .bor_en(bor_en),
    .cfg_valid(cfg_valid), .cfg_words(cfg_words), .shadow_words(shadow_words),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .status_o(status_o),
    .cm_reset_req(cm_reset_req), .bor_seen(bor_seen)
  );

  function automatic logic words_agree(logic [BW-1:0] c, logic [BW-1:0] s);
    for (int i = 0; i < NW; i++)
      if (c[i*WW +: WW] !== ~s[i*WW +: WW]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [7:0] exp_status();
    return {2'b00, m_cm, 3'b000, m_por, m_bor};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic update_model();
    logic mm, hit;
    mm  = cfg_valid && !words_agree(cfg_words, shadow_words);
    hit = mm && m_armed;
    m_por   = por_evt ? 1'b0 : (m_por | (sw_we & sw_wdata[1]));
    m_bor   = (por_evt || (bor_evt && bor_en)) ? 1'b0 : (m_bor | (sw_we & sw_wdata[0]));
    m_cm    = hit ? 1'b0 : (m_cm | (sw_we & sw_wdata[5]));
    m_armed = !mm;
    m_req   = hit;
  endtask

  task automatic idle();
    por_evt = 0; bor_evt = 0; sw_we = 0; sw_wdata = 8'h00;
    cfg_valid = 1; cfg_words = BASE; shadow_words = ~BASE;
  endtask

  task automatic step(string tag);
    @(negedge clk);
    check(tag, status_o, exp_status(), "status");
    check(tag, {7'd0, cm_reset_req}, {7'd0, m_req}, "cm_reset_req");
    check("R9", {7'd0, bor_seen}, {7'd0, bor_en & m_por & ~m_bor}, "bor_seen");
  endtask

  task automatic apply(string tag);
    update_model();
    step(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240601));
    cfg_words = BASE; shadow_words = ~BASE; cfg_valid = 0;
    m_por = 0; m_bor = 0; m_cm = 1; m_armed = 1; m_req = 0;
    repeat (3) @(negedge clk);
    check("R1", status_o, 8'h20, "status in reset");
    rst_n = 1'b1;
    update_model();
    step("R1");
    check("R1", status_o, 8'h20, "status after release");

    idle(); bor_en = 1; apply("R9");
    idle(); sw_we = 1; sw_wdata = 8'h02; apply("R4");
    idle(); apply("R9");
    idle(); bor_en = 0; apply("R9");
    idle(); sw_we = 1; sw_wdata = 8'hDC; apply("R4");
    idle(); sw_we = 1; sw_wdata = 8'h01; apply("R4");
    idle(); bor_en = 0; bor_evt = 1; apply("R3");
    idle(); bor_en = 1; bor_evt = 1; apply("R3");
    idle(); sw_we = 1; sw_wdata = 8'h23; por_evt = 1; apply("R5");
    idle(); sw_we = 1; sw_wdata = 8'h03; apply("R4");
    idle(); bor_en = 1; bor_evt = 1; sw_we = 1; sw_wdata = 8'h01; apply("R5");
    for (int k = 0; k < 5; k++) begin
      idle(); shadow_words[2*WW + 3] = ~shadow_words[2*WW + 3]; apply(k == 0 ? "R6" : "R7");
    end
    idle(); apply("R7");
    idle(); shadow_words[0] = ~shadow_words[0]; apply("R6");
    idle(); sw_we = 1; sw_wdata = 8'h20; apply("R4");
    for (int k = 0; k < 3; k++) begin
      idle(); cfg_valid = 0; shadow_words[BW-1] = ~shadow_words[BW-1]; apply("R8");
    end
    idle(); shadow_words[BW-1] = ~shadow_words[BW-1]; apply("R6");
    idle(); sw_we = 1; sw_wdata = 8'h03; apply("R10");
    idle(); shadow_words[5] = ~shadow_words[5]; apply("R10");
    idle(); por_evt = 1; apply("R10");
    idle(); bor_en = 1; bor_evt = 1; apply("R10");

    for (int n = 0; n < 3000; n++) begin
      idle();
      por_evt   = ($urandom_range(15) == 0);
      bor_evt   = ($urandom_range(7) == 0);
      bor_en    = $urandom_range(1);
      sw_we     = ($urandom_range(3) == 0);
      sw_wdata  = 8'($urandom);
      cfg_valid = ($urandom_range(7) != 0);
      cfg_words = {$urandom, $urandom};
      shadow_words = ~cfg_words;
      if ($urandom_range(4) == 0) shadow_words[$urandom_range(BW-1)] ^= 1'b1;
      apply("R10");
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule